// File: doc/BRIEF.md
# Serial Flash Command and Status Front End

This block is the command front end of a serial flash device. It sits behind a four-wire SPI slave port (active-low select, serial clock, data in, data out with a drive enable). It takes one-byte opcodes, most significant bit first, and keeps an 8-bit status byte. That byte combines a write-enable latch, a busy flag, two error flags, three block-protect bits and a status-lock bit. The memory array is not modelled. A program/erase stub only starts a busy timer of `BUSY_CYC` system clocks, which stands in for the internal operation.

The SPI pins are brought into the system clock domain by two-stage synchronizers, and serial clock edges are found there. The system clock must therefore run well above the serial clock rate. The asynchronous reset input models power-up. A host arms writes with the enable opcode, issues a status write or an operation start, and then polls status until the busy flag drops.

Top module: `sflash_stat`

## Requirements
- R1: After reset every status bit is 0, `so_oe` is 0, and the port waits for an opcode.
- R2: The status byte has this fixed bit layout: bit 7 status-lock, bit 6 program-error, bit 5 erase-error, bits 4..2 block-protect (bit 4 most significant), bit 1 write-enable latch, bit 0 busy. The error bits read 0.
- R3: Opcode 0x05 (status read) is accepted at any time, including while busy. After its 8 opcode bits, the status byte is sent MSB first, and it repeats for as long as select stays low. Each repeat is re-sampled at its byte boundary, so it carries fresh values.
- R4: `so_oe` is 0 during the opcode byte and whenever `cs_n` is high.
- R5: SPI modes 0 and 3 both work. `si` is sampled on the rising edge of `sck`, and `so` changes only after a falling edge of `sck`.
- R6: Opcode 0x06 sets the write-enable latch, and opcode 0x04 clears it.
- R7: Opcode 0x01 followed by a data byte, with the latch set, copies data bits 7 and 4..2 into status bits 7 and 4..2. Data bits 6, 5, 1 and 0 have no effect. The command then sets busy for `BUSY_CYC` clocks, and at the end clears both busy and the latch.
- R8: Opcode 0x02 with the latch set sets busy for `BUSY_CYC` clocks. At the end it clears busy and the latch.
- R9: Opcodes 0x01 and 0x02 are ignored while the latch is 0.
- R10: While busy, every opcode except 0x05 is ignored.
- R11: A command runs only when `cs_n` rises on a byte boundary after a whole opcode. Opcode 0x01 also needs its complete data byte.
- R12: Opcodes outside the five listed leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` (0 = high impedance) |

## Verification
A wrong latch or protect value shows up on the very next status read, within 16 serial clocks of select going low. A busy timer that is off by a large amount shows up as busy appearing or vanishing too early across repeated bytes of one long status read. A shifter whose bit count has slipped corrupts the byte alignment of the streamed status at once. It also makes commands that end on a boundary silently vanish, which the following read exposes.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam logic [7:0] CMD_SETREG  = 8'h01;
  localparam logic [7:0] CMD_OPSTART = 8'h02;
  localparam logic [7:0] CMD_DISARM  = 8'h04;
  localparam logic [7:0] CMD_STATUS  = 8'h05;
  localparam logic [7:0] CMD_ARM     = 8'h06;

  typedef struct packed {
    logic       reg_lock;
    logic       prog_fail;
    logic       erase_fail;
    logic [2:0] protect;
    logic       wr_en;
    logic       busy;
  } stat_t;
endpackage

// File: rtl/sfs_pins.sv
module sfs_pins #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_act,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  localparam int W = 3;
  localparam logic [W-1:0] IDLE = 3'b100;

  logic [W-1:0] stg_q [STAGES];
  logic [1:0]   prev_q;
  logic         cs_n_s, sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= IDLE;
      prev_q <= 2'b10;
    end else begin
      stg_q[0] <= {cs_n, sck, si};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= {cs_n_s, sck_s};
    end
  end

  assign {cs_n_s, sck_s, si_s} = stg_q[STAGES-1];
  assign cs_act   = !cs_n_s;
  assign cs_rise  = cs_n_s && !prev_q[1];
  assign sck_rise = sck_s && !prev_q[0];
  assign sck_fall = !sck_s && prev_q[0];
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       cs_rise,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       si_s,
  input  logic [7:0] stat_in,
  output logic       so,
  output logic       so_oe,
  output logic       exec,
  output logic [7:0] opcode,
  output logic [7:0] data,
  output logic       has_data
);
  logic [2:0] bit_q, bit_d;
  logic [1:0] cnt_q, cnt_d;
  logic [7:0] rx_q, rx_d, op_q, op_d, dat_q, dat_d, tx_q, tx_d;
  logic       stream_q, stream_d;
  logic [7:0] byte_in;

  assign byte_in = {rx_q[6:0], si_s};

  always_comb begin
    bit_d = bit_q; cnt_d = cnt_q; rx_d = rx_q; op_d = op_q;
    dat_d = dat_q; tx_d = tx_q; stream_d = stream_q;
    if (!cs_act) begin
      bit_d = '0; cnt_d = '0; stream_d = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_d  = byte_in;
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          if (cnt_q == 2'd0) begin
            op_d     = byte_in;
            stream_d = (byte_in == CMD_STATUS);
          end
          if (cnt_q == 2'd1) dat_d = byte_in;
          if (cnt_q != 2'd2) cnt_d = cnt_q + 2'd1;
        end
      end
      if (sck_fall && stream_q) begin
        if (bit_q == 3'd0) tx_d = stat_in;
        else               tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0; cnt_q <= '0; rx_q <= '0; op_q <= '0;
      dat_q <= '0; tx_q <= '0; stream_q <= 1'b0;
    end else begin
      bit_q <= bit_d; cnt_q <= cnt_d; rx_q <= rx_d; op_q <= op_d;
      dat_q <= dat_d; tx_q <= tx_d; stream_q <= stream_d;
    end
  end

  assign so       = tx_q[7];
  assign so_oe    = stream_q && cs_act;
  assign exec     = cs_rise && (bit_q == 3'd0) && (cnt_q != 2'd0);
  assign opcode   = op_q;
  assign data     = dat_q;
  assign has_data = (cnt_q == 2'd2);

  // R5
  tx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_q) |-> $past(sck_fall));
  // R11
  cmd_phase_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (!stream_q && bit_q == 3'd0 && cnt_q == 2'd0));
endmodule

// File: rtl/sfs_core.sv
module sfs_core
  import sfs_pkg::*;
#(
  parameter int BUSY_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [7:0] opcode,
  input  logic [7:0] data,
  input  logic       has_data,
  output stat_t      stat
);
  localparam int TW = $clog2(BUSY_CYC + 1);

  logic          lock_q, lock_d, wen_q, wen_d, busy_q, busy_d;
  logic [2:0]    prot_q, prot_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    lock_d = lock_q; prot_d = prot_q; wen_d = wen_q;
    busy_d = busy_q; tmr_d = tmr_q;
    if (busy_q) begin
      if (tmr_q == '0) begin
        busy_d = 1'b0;
        wen_d  = 1'b0;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end else if (exec) begin
      unique case (opcode)
        CMD_ARM:    wen_d = 1'b1;
        CMD_DISARM: wen_d = 1'b0;
        CMD_SETREG: if (wen_q && has_data) begin
          lock_d = data[7];
          prot_d = data[4:2];
          busy_d = 1'b1;
          tmr_d  = TW'(BUSY_CYC - 1);
        end
        CMD_OPSTART: if (wen_q) begin
          busy_d = 1'b1;
          tmr_d  = TW'(BUSY_CYC - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0; prot_q <= '0; wen_q <= 1'b0;
      busy_q <= 1'b0; tmr_q <= '0;
    end else begin
      lock_q <= lock_d; prot_q <= prot_d; wen_q <= wen_d;
      busy_q <= busy_d; tmr_q <= tmr_d;
    end
  end

  assign stat = '{reg_lock: lock_q, prog_fail: 1'b0, erase_fail: 1'b0,
                  protect: prot_q, wr_en: wen_q, busy: busy_q};

  // R9
  busy_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wen_q));
  // R8
  wen_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wen_q);
  // R10
  prot_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable({lock_q, prot_q}));
  // R10
  no_arm_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_q) |-> !$rose(wen_q));
endmodule

// File: rtl/sflash_stat.sv
module sflash_stat
  import sfs_pkg::*;
#(
  parameter int BUSY_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  logic [1:0] rst_q;
  logic       rst_s_n;
  logic       cs_act, cs_rise, sck_rise, sck_fall, si_s;
  logic       exec, has_data;
  logic [7:0] opcode, data;
  stat_t      stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s_n = rst_q[1];

  sfs_pins #(.STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_s_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .si_s(si_s));

  sfs_shifter u_shift (
    .clk(clk), .rst_n(rst_s_n), .cs_act(cs_act), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
    .stat_in(stat), .so(so), .so_oe(so_oe), .exec(exec),
    .opcode(opcode), .data(data), .has_data(has_data));

  sfs_core #(.BUSY_CYC(BUSY_CYC)) u_core (
    .clk(clk), .rst_n(rst_s_n), .exec(exec), .opcode(opcode),
    .data(data), .has_data(has_data), .stat(stat));
endmodule

// File: tb/sflash_stat_bench.sv
module sflash_stat_bench;
  localparam int BUSY = 1000;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  int total = 0, bad = 0;
  logic mode3 = 1'b0;
  logic m_lock = 1'b0, m_wen = 1'b0;
  logic [2:0] m_prot = 3'b0;

  always #10 clk = ~clk;

  sflash_stat #(.BUSY_CYC(BUSY)) u_sflash_stat (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe));

  function automatic logic [7:0] exp_stat();
    return {m_lock, 2'b00, m_prot, m_wen, 1'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic spi_begin(input logic m3);
    mode3 = m3; sck = m3; wclk(HALF);
    cs_n = 1'b0; wclk(HALF);
  endtask

  task automatic spi_bits(input int n, input logic [7:0] tx, output logic [7:0] rx,
                          output logic oe_any);
    rx = '0; oe_any = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = tx[i];
      wclk(HALF); @(negedge clk);
      rx = {rx[6:0], so}; oe_any |= so_oe;
      sck = 1'b1; wclk(HALF);
    end
  endtask

  task automatic spi_end();
    if (!mode3) begin sck = 1'b0; wclk(HALF); end
    cs_n = 1'b1; wclk(2 * HALF);
  endtask

  task automatic send(input logic m3, input logic [7:0] op, input logic [7:0] dat,
                      input int nb);
    logic [7:0] r; logic o;
    spi_begin(m3);
    spi_bits(8, op, r, o);
    if (nb > 1) spi_bits(8, dat, r, o);
    spi_end();
  endtask

  task automatic rdsr(input logic m3, output logic [7:0] st, output logic oe_cmd);
    logic o;
    spi_begin(m3);
    spi_bits(8, 8'h05, st, oe_cmd);
    spi_bits(8, 8'h00, st, o);
    spi_end();
  endtask

  task automatic read_check(input string req, input logic m3, input logic [7:0] exp);
    logic [7:0] st; logic oe;
    rdsr(m3, st, oe);
    check(req, st, exp);
  endtask

  initial begin
    wclk(190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] st, r, op, dat, base; logic oe, o, done, ok;
    void'($urandom(32'd4242));
    wclk(5); rst_n = 1'b1; wclk(5);
    @(negedge clk);
    check("R1 oe after reset", {7'b0, so_oe}, 8'h00);
    rdsr(1'b0, st, oe);
    check("R1 status after reset", st, 8'h00);
    check("R4 oe in opcode byte", {7'b0, oe}, 8'h00);
    @(negedge clk);
    check("R4 oe with cs high", {7'b0, so_oe}, 8'h00);

    send(1'b0, 8'h01, 8'hFF, 2);
    read_check("R9 status write without latch", 1'b0, 8'h00);
    send(1'b1, 8'h02, 8'h00, 1);
    read_check("R9 op start without latch", 1'b1, 8'h00);

    send(1'b0, 8'h06, 8'h00, 1);
    read_check("R6 arm", 1'b0, 8'h02);
    send(1'b1, 8'h9A, 8'h00, 1);
    read_check("R12 unknown opcode", 1'b1, 8'h02);
    send(1'b0, 8'h01, 8'h00, 1);
    read_check("R11 status write lacking data", 1'b0, 8'h02);
    spi_begin(1'b0); spi_bits(8, 8'h04, r, o); spi_bits(3, 8'h00, r, o); spi_end();
    read_check("R11 disarm off boundary", 1'b0, 8'h02);
    spi_begin(1'b1); spi_bits(5, 8'h04, r, o); spi_end();
    read_check("R11 partial opcode", 1'b1, 8'h02);
    send(1'b0, 8'h04, 8'h00, 1);
    read_check("R6 disarm", 1'b0, 8'h00);

    send(1'b0, 8'h06, 8'h00, 1);
    send(1'b0, 8'h01, 8'hFF, 2);
    read_check("R3 R7 read while busy", 1'b0, 8'h9F);
    send(1'b1, 8'h04, 8'h00, 1);
    read_check("R10 disarm ignored while busy", 1'b1, 8'h9F);
    send(1'b0, 8'h01, 8'h00, 2);
    wclk(BUSY + 100);
    read_check("R7 R10 done clears busy and latch", 1'b0, 8'h9C);

    send(1'b0, 8'h06, 8'h00, 1);
    send(1'b0, 8'h02, 8'h00, 1);
    base = 8'h9C; done = 1'b0; ok = 1'b1;
    spi_begin(1'b0);
    spi_bits(8, 8'h05, r, o);
    for (int k = 0; k < 14; k++) begin
      spi_bits(8, 8'h00, r, o);
      if (k == 0) check("R3 R8 first streamed byte busy", r, base | 8'h03);
      if (r == base) done = 1'b1;
      else if (done || r != (base | 8'h03)) ok = 1'b0;
    end
    spi_end();
    check("R3 R8 stream shows busy end", {6'b0, done, ok}, 8'h03);

    send(1'b0, 8'h06, 8'h00, 1);
    send(1'b1, 8'h01, 8'h67, 2);
    wclk(BUSY + 100);
    read_check("R2 R7 masked data bits", 1'b1, 8'h04);

    m_lock = 1'b0; m_prot = 3'b001; m_wen = 1'b0;
    for (int it = 0; it < 30; it++) begin
      int kind; logic m3; logic busy;
      kind = $urandom_range(0, 5); m3 = 1'($urandom_range(0, 1));
      dat = 8'($urandom); busy = 1'b0;
      case (kind)
        0: begin send(m3, 8'h06, dat, 1); m_wen = 1'b1; end
        1: begin send(m3, 8'h04, dat, 1); m_wen = 1'b0; end
        2: begin
          send(m3, 8'h01, dat, 2);
          if (m_wen) begin m_lock = dat[7]; m_prot = dat[4:2]; m_wen = 1'b0; busy = 1'b1; end
        end
        3: begin send(m3, 8'h02, dat, 1); if (m_wen) begin m_wen = 1'b0; busy = 1'b1; end end
        4: begin
          op = 8'($urandom);
          if (op inside {8'h01, 8'h02, 8'h04, 8'h05, 8'h06}) op = 8'hA5;
          send(m3, op, dat, 1);
        end
        default: begin
          spi_begin(m3); spi_bits($urandom_range(1, 7), 8'h06, r, o); spi_end();
        end
      endcase
      if (busy) wclk(BUSY + 100);
      read_check("R5 R6 R7 R8 R9 R12 random", 1'(~m3), exp_stat());
    end

    send(1'b0, 8'h06, 8'h00, 1);
    send(1'b0, 8'h02, 8'h00, 1);
    rst_n = 1'b0; wclk(4); rst_n = 1'b1; wclk(5);
    read_check("R1 reset during busy", 1'b0, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule